// File: doc/BRIEF.md
# Farrow Fractional-Rate Resampler

This block lowers the sample rate of a signed stream by any ratio strictly between 1 and 2. Several fixed-coefficient FIR branches run side by side on every accepted input. Each branch is a transposed FIR whose taps are small integers, so it needs only shifts and adds. A polynomial in a fractional-delay control `mu` then combines the branch outputs. This polynomial is evaluated in Horner form through a pipeline of `ORDER` multiplier stages, and these are the only variable multipliers in the block.

A phase accumulator adds the fractional part of the ratio once per output. It does two jobs: it gives the fractional delay of each output, and it decides whether one or two new inputs are needed before the next output. Upstream logic feeds samples with a valid strobe and holds the ratio word steady. The block returns one resampled value per output event, marked by its own valid strobe.

Top module: `farrow_resampler`

## Requirements
- R1: `ratio` is unsigned fixed point, one integer bit above 16 fractional bits. Bit 16 must be 1 and bits 15:0 nonzero, so the ratio lies strictly between 1 and 2. The fractional step `f` is `ratio[15:0]`.
- R2: `in_ready` is 0 while `rst` is high and 1 at all other times. A sample is accepted on each clock edge where `in_valid` and `in_ready` are both high.
- R3: The first output is formed when the first sample after reset is accepted. Each later output needs one more accepted sample, or two when the previous output's delay plus `f` reaches or passes 65536. So after N accepted samples the number of outputs is the largest n with n + floor(n*f/65536) <= N.
- R4: Output number n (counting from 1) has delay d_n = (n*f) mod 65536, held in 16 fractional bits. Its control is mu = 32768 - d_n, a signed value with 16 fractional bits.
- R5: Branch m (0..ORDER) is a (ORDER+1)-tap FIR over the newest accepted sample x[0] and older samples x[k]. Tap k has weight (-1)^k * binomial(m,k) for k <= m and 0 otherwise.
- R6: Let c_m be the branch outputs. The result starts at a = c_ORDER. Then for m = ORDER-1 down to 0 it is updated as a = floor(a*mu / 65536) + c_m, and the final a is `out_data`.
- R7: `out_valid` pulses for one cycle, ORDER+1 cycles after the cycle in which the sample that completes that output is accepted.
- R8: Reset clears every branch history sample to zero, sets the accumulator to zero and empties the pipeline. `out_valid` is 0 in the cycle after any cycle with `rst` high.
- R9: Cycles with `in_valid` low change nothing. Outputs and their values depend only on the sequence of accepted samples, whatever the idle gaps between them.
- R10: Every launched `mu` lies in the range -32767 to 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio | input | 17 | Downsampling ratio, 1.16 unsigned fixed point |
| in_valid | input | 1 | Input sample strobe |
| in_ready | output | 1 | Input can be accepted |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DW+ORDER+2 | Signed resampled value |

## Verification
The embedded properties check the following on every cycle:
- the legal ratio range;
- the pending-input count staying at one or two;
- launches only following an accepted sample;
- the mu range;
- the fixed ORDER+1 latency from accept to output;
- silence after reset.

Only the bench's scenarios can show that the values are right. The scoreboard checks each value against a polynomial model that is built from the tap and Horner definitions. The bench also compares output counts against the closed-form count per ratio, shows that idle gaps leave the results unchanged, and shows that a mid-stream reset really flushes stale history.

// File: rtl/farrow_pkg.sv
package farrow_pkg;
   localparam int FRAC_W = 16;
   localparam int MU_W   = FRAC_W + 2;

   function automatic int binom(input int n, input int k);
      int r;
      r = 1;
      for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
      return r;
   endfunction

   // Branch m forms the m-th backward difference of the input history.
   function automatic int tap(input int m, input int k);
      if (k > m) return 0;
      return (k % 2 == 1) ? -binom(m, k) : binom(m, k);
   endfunction
endpackage

// File: rtl/farrow_branch.sv
module farrow_branch #(
   parameter int DW = 16,
   parameter int ORDER = 3,
   parameter int M = 0,
   localparam int T = ORDER + 1,
   localparam int CW = DW + ORDER + 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic signed [DW-1:0] x,
   output logic signed [CW-1:0] y
);
   logic signed [CW-1:0] xe;
   logic signed [CW-1:0] term [T];
   logic signed [CW-1:0] st [T-1];

   assign xe = CW'(x);

   for (genvar k = 0; k < T; k++) begin : g_tap
      localparam int H = farrow_pkg::tap(M, k);
      assign term[k] = xe * CW'(H);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         y <= '0;
         for (int k = 0; k < T - 1; k++) st[k] <= '0;
      end else if (en) begin
         y <= term[0] + st[0];
         for (int k = 0; k < T - 2; k++) st[k] <= term[k+1] + st[k+1];
         st[T-2] <= term[T-1];
      end
   end
endmodule

// File: rtl/farrow_phase.sv
module farrow_phase #(
   localparam int FW = farrow_pkg::FRAC_W,
   localparam int MW = farrow_pkg::MU_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 accept,
   input  logic [FW-1:0]        step,
   output logic                 launch,
   output logic signed [MW-1:0] mu
);
   logic [FW-1:0] acc;
   logic [FW-1:0] d;
   logic [1:0]    pend;
   logic          carry;

   assign d     = acc + step;
   assign carry = ({1'b0, d} + {1'b0, step}) > {1'b0, {FW{1'b1}}};

   always_ff @(posedge clk) begin
      if (rst) begin
         acc    <= '0;
         pend   <= 2'd1;
         launch <= 1'b0;
         mu     <= '0;
      end else begin
         launch <= 1'b0;
         if (accept) begin
            if (pend == 2'd1) begin
               acc    <= d;
               pend   <= carry ? 2'd2 : 2'd1;
               launch <= 1'b1;
               mu     <= $signed(MW'(1 << (FW - 1))) - $signed({2'b00, d});
            end else begin
               pend <= pend - 2'd1;
            end
         end
      end
   end

   p_pend_r3: assert property (@(posedge clk) disable iff (rst)
      (pend == 2'd1) || (pend == 2'd2));
   p_launch_r3: assert property (@(posedge clk) disable iff (rst)
      launch |-> $past(accept));
   p_mu_r10: assert property (@(posedge clk) disable iff (rst)
      launch |-> (mu > -$signed(MW'(32768)) && mu <= $signed(MW'(32768))));
endmodule

// File: rtl/farrow_horner.sv
module farrow_horner #(
   parameter int DW = 16,
   parameter int ORDER = 3,
   localparam int CW = DW + ORDER + 1,
   localparam int AW = DW + ORDER + 2,
   localparam int FW = farrow_pkg::FRAC_W,
   localparam int MW = farrow_pkg::MU_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic signed [MW-1:0] mu,
   input  logic signed [CW-1:0] c_in [ORDER+1],
   output logic                 y_valid,
   output logic signed [AW-1:0] y
);
   for (genvar i = 1; i <= ORDER; i++) begin : g_st
      logic                 v_d, v_q;
      logic signed [MW-1:0] mu_d;
      logic signed [AW-1:0] a_d, a_q;
      logic signed [CW-1:0] c_d [ORDER+1];
      logic signed [AW+MW-1:0] prod;

      if (i == 1) begin : g_head
         assign v_d  = start;
         assign mu_d = mu;
         assign a_d  = AW'(c_in[ORDER]);
         assign c_d  = c_in;
      end else begin : g_tail
         assign v_d  = g_st[i-1].v_q;
         assign mu_d = g_st[i-1].g_fwd.mu_q;
         assign a_d  = g_st[i-1].a_q;
         assign c_d  = g_st[i-1].g_fwd.c_q;
      end

      assign prod = a_d * mu_d;

      always_ff @(posedge clk) begin
         if (rst) v_q <= 1'b0;
         else     v_q <= v_d;
         a_q <= AW'(prod >>> FW) + AW'(c_d[ORDER-i]);
      end

      if (i < ORDER) begin : g_fwd
         logic signed [MW-1:0] mu_q;
         logic signed [CW-1:0] c_q [ORDER+1];
         always_ff @(posedge clk) begin
            mu_q <= mu_d;
            c_q  <= c_d;
         end
      end
   end

   assign y_valid = g_st[ORDER].v_q;
   assign y       = g_st[ORDER].a_q;
endmodule

// File: rtl/farrow_resampler.sv
module farrow_resampler #(
   parameter int DW = 16,
   parameter int ORDER = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [16:0]                ratio,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic signed [DW-1:0]       in_data,
   output logic                       out_valid,
   output logic signed [DW+ORDER+1:0] out_data
);
   localparam int CW = DW + ORDER + 1;
   localparam int MW = farrow_pkg::MU_W;

   if (ORDER < 1 || ORDER > 6) begin : g_bad_order
      $error("ORDER must lie in 1..6");
   end
   if (DW < 4 || DW > 32) begin : g_bad_width
      $error("DW must lie in 4..32");
   end

   logic                 accept;
   logic                 launch;
   logic signed [MW-1:0] mu;
   logic signed [CW-1:0] c_all [ORDER+1];

   assign in_ready = !rst;
   assign accept   = in_valid && in_ready;

   for (genvar m = 0; m <= ORDER; m++) begin : g_branch
      farrow_branch #(.DW(DW), .ORDER(ORDER), .M(m)) u_branch (
         .clk(clk), .rst(rst), .en(accept), .x(in_data), .y(c_all[m]));
   end

   farrow_phase u_phase (
      .clk(clk), .rst(rst), .accept(accept), .step(ratio[15:0]),
      .launch(launch), .mu(mu));

   farrow_horner #(.DW(DW), .ORDER(ORDER)) u_horner (
      .clk(clk), .rst(rst), .start(launch), .mu(mu), .c_in(c_all),
      .y_valid(out_valid), .y(out_data));

   p_ratio_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (ratio[16] && ratio[15:0] != 16'd0));
   p_latency_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid && in_ready, ORDER + 1));
   p_quiet_r8: assert property (@(posedge clk)
      rst |=> !out_valid);
endmodule

// File: tb/farrow_resampler_bench.sv
module farrow_resampler_bench;
   localparam int DW = 16;
   localparam int L  = 3;
   localparam int T  = L + 1;
   localparam int OW = DW + L + 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [16:0] ratio = 17'h10001;
   logic in_valid = 1'b0;
   logic in_ready;
   logic signed [DW-1:0] in_data = '0;
   logic out_valid;
   logic signed [OW-1:0] out_data;

   always #10 clk = ~clk;

   farrow_resampler #(.DW(DW), .ORDER(L)) u_farrow_resampler (
      .clk(clk), .rst(rst), .ratio(ratio), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, fails = 0;
   longint exp_q[$];
   int due_q[$];
   longint hist [T];
   longint m_acc;
   int m_pend, n_acc, n_seen;
   bit done = 0;

   function automatic longint bn(input int n, input int k);
      longint r = 1;
      for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
      return r;
   endfunction

   function automatic longint wt(input int m, input int k);
      if (k > m) return 0;
      return (k % 2 == 1) ? -bn(m, k) : bn(m, k);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < T; k++) hist[k] = 0;
      m_acc = 0; m_pend = 1; n_acc = 0; n_seen = 0;
      exp_q.delete(); due_q.delete();
   endtask

   // R3, R4, R5, R6 reference model
   task automatic model_push(input longint x, input int edge_idx);
      longint f, d, mu, a;
      longint c [T];
      f = longint'(ratio[15:0]);
      for (int k = T - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      n_acc++;
      m_pend--;
      if (m_pend == 0) begin
         d = (m_acc + f) % 65536;
         m_acc = d;
         mu = 32768 - d;
         for (int m = 0; m < T; m++) begin
            c[m] = 0;
            for (int k = 0; k < T; k++) c[m] += wt(m, k) * hist[k];
         end
         a = c[L];
         for (int m = L - 1; m >= 0; m--) a = ((a * mu) >>> 16) + c[m];
         exp_q.push_back(a);
         due_q.push_back(edge_idx + L);
         m_pend = ((d + f) > 65535) ? 2 : 1;
      end
   endtask

   task automatic send(input longint x);
      in_valid = 1'b1;
      in_data = DW'(x);
      model_push(x, cyc + 1);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      int guard = 0;
      in_valid = 1'b0;
      while (exp_q.size() != 0 && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      repeat (L + 3) @(negedge clk);
      check(exp_q.size() == 0, "R7 outputs drained", exp_q.size(), 0);
   endtask

   function automatic int count_out(input longint n_in, input longint f);
      int n = 0;
      while ((n + 1) + ((n + 1) * f) / 65536 <= n_in) n++;
      return n;
   endfunction

   // scoreboard monitor: R4 R5 R6 values, R7 timing
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         n_seen++;
         if (exp_q.size() == 0) begin
            check(0, "R3 unexpected output", longint'(out_data), 0);
         end else begin
            longint e;
            int dd;
            e = exp_q.pop_front();
            dd = due_q.pop_front();
            check(longint'(out_data) == e, "R4 R5 R6 value", longint'(out_data), e);
            check(cyc == dd, "R7 latency", cyc, dd);
         end
      end
   end

   task automatic run_stream(input int step, input int n, input int mode);
      longint x;
      ratio = {1'b1, 16'(step)};
      for (int i = 1; i <= n; i++) begin
         if (mode == 0) x = 100 * i;
         else x = longint'($signed(16'($urandom)));
         send(x);
         if (mode == 2 && ($urandom % 3) == 0) idle(1 + int'($urandom % 4));
      end
      drain();
      check(n_seen == count_out(n, step), "R3 output count", n_seen, count_out(n, step));
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b0, "R2 ready low in reset", in_ready, 0);
      @(negedge clk);
      check(out_valid == 1'b0, "R8 no output in reset", out_valid, 0);
      rst = 1'b0;
      model_reset();
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check(in_ready == 1'b0, "R2 ready low in reset", in_ready, 0);
      check(out_valid == 1'b0, "R8 reset state", out_valid, 0);
      rst = 1'b0;
      @(negedge clk);
      check(in_ready == 1'b1, "R2 ready after reset", in_ready, 1);
      // R4: step 0.2 on a ramp
      run_stream(13107, 40, 0);
      pulse_reset();
      run_stream(32768, 60, 1);
      pulse_reset();
      run_stream(65535, 60, 1);     // R1 ratio just below 2
      pulse_reset();
      run_stream(1, 30, 1);         // R1 ratio just above 1
      pulse_reset();
      run_stream(40000, 80, 2);     // R9 idle gaps
      // R8: leave history full of large values, then reset mid-stream
      ratio = {1'b1, 16'd20000};
      for (int i = 0; i < 5; i++) send(30000);
      idle(1);
      pulse_reset();
      run_stream(20000, 20, 0);
      pulse_reset();
      run_stream(50000, 500, 2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule